// File: doc/BRIEF.md
# Bitwise Execute Unit for Split, Bit-Equal and Masked Merge

This block is the execute stage for three extra register-to-register operations in a 32-bit load/store processor. Each cycle it may accept one decoded operation together with the two source register values, a 16-bit immediate and the two register numbers the operation may write. One clock later it presents up to two register write-back requests. Each request carries an enable, a destination number and data.

Port A always returns a result aimed at the `rd` register. Port B always returns a result aimed at the `rt` register.

The split operation fills both ports in the same cycle. The bit-equal operation uses only port A. The masked merge uses only port B, so its result goes back to `rt`, which is one of its own sources.

An operation code the unit does not know raises a flag and writes nothing. All outputs are registered, with a synchronous active-high reset.

Top module: `bitop_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero in the following cycle.
- R2: Outputs reflect the inputs sampled at the previous rising edge, a latency of exactly one cycle.
- R3: The split operation (op code 1) drives port A with enable 1, index `rd_idx` and data equal to the low half of `rs_val` with the upper half zero.
- R4: The split operation also drives port B with enable 1, index `rt_idx` and data equal to `rs_val` shifted right logically by half the data width.
- R5: The bit-equal operation (op code 2) drives port A with index `rd_idx` and data bit i equal to 1 exactly when bit i of `rs_val` equals bit i of `rt_val`. Port B stays disabled.
- R6: The merge operation (op code 3) builds its mask by sign-extending `imm16` (bit 15 is the sign) to the data width.
- R7: The merge operation drives only port B, with index `rt_idx`. Each data bit comes from `rs_val` where the mask bit is 1 and from `rt_val` where it is 0.
- R8: A valid operation whose code is not 1, 2 or 3 leaves both enables low and sets `illegal_op` for one cycle.
- R9: When `in_valid` is low, both enables and `illegal_op` are low in the next cycle, whatever the op code.
- R10: A write port whose enable is low shows index and data of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation: 1 split, 2 bit-equal, 3 merge |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| imm16 | input | 16 | Immediate, used as the merge mask |
| rd_idx | input | 5 | Register number for port A |
| rt_idx | input | 5 | Register number for port B |
| wa_en | output | 1 | Port A write enable |
| wa_idx | output | 5 | Port A destination register |
| wa_data | output | 32 | Port A write data |
| wb_en | output | 1 | Port B write enable |
| wb_idx | output | 5 | Port B destination register |
| wb_data | output | 32 | Port B write data |
| illegal_op | output | 1 | Unknown op code was presented |

## Verification
The bench builds the unit at its default sizes: 32-bit data, a 16-bit immediate and 5-bit register numbers. These sizes make the split boundary fall at bit 16. They also mean the sign extension replicates bit 15 across the upper sixteen bits, so the immediates 0x0000, 0x7FFF, 0x8000 and 0xFFFF cover every shape the mask can take. At this size the five unused op codes can all be tried, and random operands and register numbers reach every bit of both write ports.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OPC_SPLIT = 3'd1;
  localparam logic [OP_W-1:0] OPC_BITEQ = 3'd2;
  localparam logic [OP_W-1:0] OPC_MERGE = 3'd3;
endpackage

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              op_vld,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  rt_idx,
  output logic              a_en,
  output logic [IDX_W-1:0]  a_idx,
  output logic [DATA_W-1:0] a_data,
  output logic              b_en,
  output logic [IDX_W-1:0]  b_idx,
  output logic [DATA_W-1:0] b_data,
  output logic              bad_op
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W - IMM_W;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] lo_half;
  logic [DATA_W-1:0] hi_half;
  logic [DATA_W-1:0] same_bits;

  assign mask      = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign lo_half   = {{(DATA_W-HALF_W){1'b0}}, rs_val[HALF_W-1:0]};
  assign hi_half   = rs_val >> HALF_W;
  assign same_bits = ~(rs_val ^ rt_val);

  for (genvar g = 0; g < DATA_W; g++) begin : g_merge
    assign merged[g] = mask[g] ? rs_val[g] : rt_val[g];
  end

  always_comb begin
    a_en   = 1'b0;
    a_idx  = '0;
    a_data = '0;
    b_en   = 1'b0;
    b_idx  = '0;
    b_data = '0;
    bad_op = 1'b0;
    if (op_vld) begin
      case (op_code)
        OPC_SPLIT: begin
          a_en   = 1'b1;
          a_idx  = rd_idx;
          a_data = lo_half;
          b_en   = 1'b1;
          b_idx  = rt_idx;
          b_data = hi_half;
        end
        OPC_BITEQ: begin
          a_en   = 1'b1;
          a_idx  = rd_idx;
          a_data = same_bits;
        end
        OPC_MERGE: begin
          b_en   = 1'b1;
          b_idx  = rt_idx;
          b_data = merged;
        end
        default: bad_op = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bitop_outreg.sv
module bitop_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/bitop_exec_unit.sv
module bitop_exec_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  rt_idx,
  output logic              wa_en,
  output logic [IDX_W-1:0]  wa_idx,
  output logic [DATA_W-1:0] wa_data,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              illegal_op
);
  localparam int PORT_W = 1 + IDX_W + DATA_W;
  localparam int PIPE_W = 2 * PORT_W + 1;

  logic              a_en, b_en, bad_op;
  logic [IDX_W-1:0]  a_idx, b_idx;
  logic [DATA_W-1:0] a_data, b_data;
  logic [PIPE_W-1:0] pipe_d, pipe_q;

  bitop_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_alu (
    .op_vld (in_valid),
    .op_code(op_code),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .imm    (imm16),
    .rd_idx (rd_idx),
    .rt_idx (rt_idx),
    .a_en   (a_en),
    .a_idx  (a_idx),
    .a_data (a_data),
    .b_en   (b_en),
    .b_idx  (b_idx),
    .b_data (b_data),
    .bad_op (bad_op)
  );

  assign pipe_d = {a_en, a_idx, a_data, b_en, b_idx, b_data, bad_op};

  bitop_outreg #(.W(PIPE_W)) u_oreg (
    .clk(clk),
    .rst(rst),
    .d  (pipe_d),
    .q  (pipe_q)
  );

  assign {wa_en, wa_idx, wa_data, wb_en, wb_idx, wb_data, illegal_op} = pipe_q;
endmodule

// File: rtl/bitop_exec_unit_chk.sv
module bitop_exec_unit_chk
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] rs_val,
  input logic [DATA_W-1:0] rt_val,
  input logic [IMM_W-1:0]  imm16,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [IDX_W-1:0]  rt_idx,
  input logic              wa_en,
  input logic [IDX_W-1:0]  wa_idx,
  input logic [DATA_W-1:0] wa_data,
  input logic              wb_en,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [DATA_W-1:0] wb_data,
  input logic              illegal_op
);
  localparam int HALF_W = DATA_W / 2;

  AST_SPLIT_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OPC_SPLIT) |=> (wa_en && wa_data[DATA_W-1:HALF_W] == '0 && wa_idx == $past(rd_idx))); // R3
  AST_SPLIT_BOTH_PORTS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OPC_SPLIT) |=> (wb_en && wb_idx == $past(rt_idx) && wb_data == ($past(rs_val) >> HALF_W))); // R4
  AST_BITEQ_PORT_A: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OPC_BITEQ) |=> (wa_en && !wb_en && (wa_data ^ $past(rs_val) ^ $past(rt_val)) == '1)); // R5
  AST_MERGE_RESULT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OPC_MERGE) |=> (!wa_en && wb_en && wb_idx == $past(rt_idx) &&
      wb_data == (($past(rs_val) & {{(DATA_W-IMM_W){$past(imm16[IMM_W-1])}}, $past(imm16)}) |
                  ($past(rt_val) & ~{{(DATA_W-IMM_W){$past(imm16[IMM_W-1])}}, $past(imm16)})))); // R7
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> (!wa_en && !wb_en)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wa_en && !wb_en && !illegal_op)); // R9
  AST_PORT_A_ZERO: assert property (@(posedge clk) disable iff (rst)
    !wa_en |-> (wa_idx == '0 && wa_data == '0)); // R10
  AST_PORT_B_ZERO: assert property (@(posedge clk) disable iff (rst)
    !wb_en |-> (wb_idx == '0 && wb_data == '0)); // R10
endmodule

bind bitop_exec_unit bitop_exec_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .rs_val(rs_val),
  .rt_val(rt_val), .imm16(imm16), .rd_idx(rd_idx), .rt_idx(rt_idx), .wa_en(wa_en),
  .wa_idx(wa_idx), .wa_data(wa_data), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
  .illegal_op(illegal_op)
);

// File: tb/bitop_exec_unit_bench.sv
module bitop_exec_unit_bench;
  localparam int DW = 32;
  localparam int IW = 16;
  localparam int XW = 5;

  typedef struct {
    logic          a_en;
    logic [XW-1:0] a_idx;
    logic [DW-1:0] a_data;
    logic          b_en;
    logic [XW-1:0] b_idx;
    logic [DW-1:0] b_data;
    logic          ill;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [DW-1:0] rs_val = '0, rt_val = '0;
  logic [IW-1:0] imm16 = '0;
  logic [XW-1:0] rd_idx = '0, rt_idx = '0;
  logic          wa_en, wb_en, illegal_op;
  logic [XW-1:0] wa_idx, wb_idx;
  logic [DW-1:0] wa_data, wb_data;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  bitop_exec_unit #(.DATA_W(DW), .IMM_W(IW), .IDX_W(XW)) u_bitop_exec_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .rs_val(rs_val),
    .rt_val(rt_val), .imm16(imm16), .rd_idx(rd_idx), .rt_idx(rt_idx), .wa_en(wa_en),
    .wa_idx(wa_idx), .wa_data(wa_data), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .illegal_op(illegal_op)
  );

  // Reference model, written from the requirements
  function automatic exp_t model(logic v, logic [2:0] op, logic [DW-1:0] s, logic [DW-1:0] t,
                                 logic [IW-1:0] im, logic [XW-1:0] d, logic [XW-1:0] tx);
    exp_t e;
    logic [DW-1:0] m;
    e.a_en = 0; e.a_idx = 0; e.a_data = 0;
    e.b_en = 0; e.b_idx = 0; e.b_data = 0;
    e.ill = 0;
    e.tag = "R9 R10";
    m = {{(DW-IW){im[IW-1]}}, im};                        // R6
    if (v) begin
      if (op == 3'd1) begin                               // R3 R4
        e.a_en = 1; e.a_idx = d;  e.a_data = {16'h0, s[15:0]};
        e.b_en = 1; e.b_idx = tx; e.b_data = {16'h0, s[31:16]};
        e.tag = "R3 R4";
      end else if (op == 3'd2) begin                      // R5
        e.a_en = 1; e.a_idx = d; e.a_data = ~(s ^ t);
        e.tag = "R5 R10";
      end else if (op == 3'd3) begin                      // R6 R7
        e.b_en = 1; e.b_idx = tx; e.b_data = (s & m) | (t & ~m);
        e.tag = "R6 R7 R10";
      end else begin                                      // R8
        e.ill = 1;
        e.tag = "R8 R10";
      end
    end
    return e;
  endfunction

  // Driver: apply inputs at the falling edge and queue the expected result
  task automatic drive(logic v, logic [2:0] op, logic [DW-1:0] s, logic [DW-1:0] t,
                       logic [IW-1:0] im, logic [XW-1:0] d, logic [XW-1:0] tx);
    @(negedge clk);
    in_valid = v; op_code = op; rs_val = s; rt_val = t; imm16 = im; rd_idx = d; rt_idx = tx;
    sb_q.push_back(model(v, op, s, t, im, d, tx));
  endtask

  // Monitor: R2, the result of the inputs taken at an edge is visible right after it
  always @(posedge clk) begin
    #2;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (wa_en !== e.a_en || wa_idx !== e.a_idx || wa_data !== e.a_data ||
          wb_en !== e.b_en || wb_idx !== e.b_idx || wb_data !== e.b_data ||
          illegal_op !== e.ill) begin
        n_fail++;
        $display("FAIL %s R2: got A=%b/%0d/%h B=%b/%0d/%h ill=%b exp A=%b/%0d/%h B=%b/%0d/%h ill=%b",
                 e.tag, wa_en, wa_idx, wa_data, wb_en, wb_idx, wb_data, illegal_op,
                 e.a_en, e.a_idx, e.a_data, e.b_en, e.b_idx, e.b_data, e.ill);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] edge_imm [4];
    edge_imm[0] = 16'h0000; edge_imm[1] = 16'h7FFF; edge_imm[2] = 16'h8000; edge_imm[3] = 16'hFFFF;
    // R1: drive a live operation during reset, outputs must stay zero
    in_valid = 1; op_code = 3'd1; rs_val = 32'hFFFF_FFFF; rd_idx = 5'd7; rt_idx = 5'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if ({wa_en, wa_idx, wa_data, wb_en, wb_idx, wb_data, illegal_op} !== '0) begin
      n_fail++;
      $display("FAIL R1: got A=%h B=%h ill=%b exp all zero", wa_data, wb_data, illegal_op);
    end
    in_valid = 0;
    rst = 0;
    // directed: split, bit-equal extremes, merge edge immediates
    drive(1, 3'd1, 32'hDEAD_BEEF, 32'h0, 16'h0, 5'd3, 5'd4);
    drive(1, 3'd1, 32'h8000_0001, 32'h0, 16'h0, 5'd31, 5'd0);
    drive(1, 3'd2, 32'h1234_5678, 32'h1234_5678, 16'h0, 5'd5, 5'd6);
    drive(1, 3'd2, 32'h5555_5555, 32'hAAAA_AAAA, 16'h0, 5'd8, 5'd9);
    foreach (edge_imm[k])
      drive(1, 3'd3, 32'hA5A5_A5A5, 32'h5A5A_5A5A, edge_imm[k], 5'd10, 5'd11);
    // R8: every unused code
    drive(1, 3'd0, 32'hFFFF_FFFF, 32'h1, 16'hFFFF, 5'd1, 5'd2);
    for (int c = 4; c < 8; c++)
      drive(1, 3'(c), 32'hFFFF_FFFF, 32'h1, 16'hFFFF, 5'd1, 5'd2);
    // R9: idle with every code present
    for (int c = 0; c < 8; c++)
      drive(0, 3'(c), 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd12, 5'd13);
    // random traffic over all codes and edge immediates
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] im;
      im = (i % 5 == 4) ? 16'($urandom) : edge_imm[i % 4];
      drive(($urandom % 8) != 0, 3'($urandom), $urandom, $urandom, im, 5'($urandom), 5'($urandom));
    end
    drive(0, 3'd0, 32'h0, 32'h0, 16'h0, 5'd0, 5'd0);
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule